// File: doc/BRIEF.md
# Register-Access Packet Responder

This block is the device-side end of a byte-serial protocol for reading and writing a paged bank of 16-bit registers. A host sends a request packet as a stream of bytes. The responder collects the packet and checks it against an 8-bit CRC. If the request is well formed, it reads or writes a run of consecutive registers within one page. It then streams back a reply packet that reports success, a corrupt request or a failed register operation, and carries any data that was read.

The register bank sits inside the block. It is organised as `NUM_PAGES` pages of `REGS_PER_PAGE` registers. One register position, chosen by parameter, acts as a latching alarm word: event pulses on an input port set its bits, and a protocol write of 1 to a bit clears that bit. Both byte streams use a valid/ready handshake. The block is half-duplex: it takes no new request bytes while a reply is pending.

Top module: `regpkt_responder`

## Requirements
- R1: After reset, the block is ready to accept request bytes (`rx_ready` high), it presents no reply byte (`tx_valid` low), and every register reads as zero.
- R2: Packet layout on both streams:
  - Byte 0 carries the register count in bits 5:0 and a 2-bit code in bits 7:6.
  - Byte 1 is the CRC, byte 2 the page and byte 3 the offset.
  - Register words follow, each sent low byte first.
  - A packet ends right after the last word given by its count.
- R3: The CRC is CRC-8 with polynomial 0x07, initial value 0 and MSB-first processing. It runs over every byte of the packet, and the CRC byte itself is counted as 0x00. It is checked on requests and generated on replies.
- R4: A valid write request (code 01, i.e. byte 0 = 0x40 | count) stores its words into consecutive registers starting at page/offset. It is answered with code 00, count 0, and the request's page and offset echoed.
- R5: A valid read request (code 00) carries no words. Its reply has code 00, the same count, page and offset, followed by that many register words.
- R6: A request whose CRC does not match gets a reply with code 01 (byte 0 = 0x40) and count 0. No register is changed.
- R7: Any of the following gets a reply with code 10 (byte 0 = 0x80) and count 0, and no register is accessed:
  - a count above 32;
  - a page at or beyond `NUM_PAGES`;
  - offset plus count beyond `REGS_PER_PAGE`;
  - request code 10 or 11, which is treated as a 4-byte packet.
- R8: The alarm word (default page 1, offset 3) ORs in every `alarm_set` pulse and holds the bits afterwards. A write to it clears exactly the bits written as 1.
- R9: While a reply is being sent, `rx_ready` stays low. A presented reply byte holds steady until `tx_ready` accepts it.
- R10: A valid request with count 0 is answered with a 4-byte success reply with count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Request byte from the host |
| rx_valid | input | 1 | Request byte present |
| rx_ready | output | 1 | Block accepts a request byte this cycle |
| tx_byte | output | 8 | Reply byte to the host |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Host accepts the reply byte this cycle |
| alarm_set | input | 16 | Event pulses latched into the alarm word |

## Verification
The following request patterns are exercised:
- Multi-word writes followed by reads at shifted offsets. A write landing at the wrong address, or swapped byte lanes, shows up as a mismatch.
- A full-page write and read-back, which reaches the page edge.
- Writes with a corrupted CRC byte, range violations, an oversized count with its full payload, and an unused request code. Each is followed by a read-back that shows whether storage was touched, and each is told apart from the others by its reply code.
- Alarm pulses followed by a partial write-one-to-clear, which separate latching from plain storage.
- A reply drained under host backpressure, which checks that bytes are held and that request acceptance is blocked.

// File: rtl/regpkt_pkg.sv
package regpkt_pkg;

    // request opcodes (header bits 7:6)
    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;

    // reply status codes (header bits 7:6)
    localparam logic [1:0] ST_OK      = 2'b00;
    localparam logic [1:0] ST_CORRUPT = 2'b01;
    localparam logic [1:0] ST_ERROR   = 2'b10;

    typedef struct packed {
        logic [1:0] code;
        logic [5:0] count;
    } hdr_t;

    typedef enum logic [2:0] {
        S_RX,
        S_CHECK,
        S_WRITE,
        S_READ,
        S_SUM,
        S_TX
    } phase_e;

    // one byte of CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] r;
        r = acc ^ din;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/regpkt_crc8_acc.sv
module regpkt_crc8_acc
    import regpkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= 8'h00;
        end else if (en) begin
            crc_q <= crc8_step(crc_q, din);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/regpkt_regfile.sv
module regpkt_regfile #(
    parameter int NUM_PAGES     = 4,
    parameter int REGS_PER_PAGE = 8,
    parameter int ALARM_PAGE    = 1,
    parameter int ALARM_OFFSET  = 3,
    localparam int ENTRIES      = NUM_PAGES * REGS_PER_PAGE,
    localparam int IDX_W        = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data,
    input  logic [15:0]      alarm_set
);

    localparam int ALARM_IDX = ALARM_PAGE * REGS_PER_PAGE + ALARM_OFFSET;

    logic [ENTRIES-1:0][15:0] store_w;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [15:0] q;
        logic        hit;
        assign hit = wr_en && (wr_idx == IDX_W'(e));

        if (e == ALARM_IDX) begin : g_alarm
            // latch on events, write-one-to-clear from the protocol side
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= 16'h0000;
                end else begin
                    q <= (hit ? (q & ~wr_data) : q) | alarm_set;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= 16'h0000;
                end else if (hit) begin
                    q <= wr_data;
                end
            end
        end

        assign store_w[e] = q;
    end

    assign rd_data = store_w[rd_idx];

endmodule

// File: rtl/regpkt_responder.sv
module regpkt_responder
    import regpkt_pkg::*;
#(
    parameter int NUM_PAGES     = 4,
    parameter int REGS_PER_PAGE = 8,
    parameter int MAX_REGS      = 32,
    parameter int ALARM_PAGE    = 1,
    parameter int ALARM_OFFSET  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [7:0]  tx_byte,
    output logic        tx_valid,
    input  logic        tx_ready,
    input  logic [15:0] alarm_set
);

    localparam int ENTRIES = NUM_PAGES * REGS_PER_PAGE;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int BUF_AW  = $clog2(MAX_REGS);

    phase_e      state_q;
    hdr_t        hdr_q;
    logic [7:0]  crc_in_q;
    logic [7:0]  page_q;
    logic [7:0]  off_q;
    logic [7:0]  rx_idx_q;
    logic [7:0]  tx_idx_q;
    logic [5:0]  widx_q;
    logic [1:0]  rcode_q;
    logic [5:0]  rcount_q;
    logic [15:0] buf_q [MAX_REGS];

    logic        rx_fire, tx_fire;
    logic [7:0]  rx_end, tx_end;
    logic        rx_last, tx_last, widx_last;
    logic        rx_in_buf;
    logic [BUF_AW-1:0] rx_slot, tx_slot;
    logic [7:0]  rx_sum, tx_sum, rx_crc_din, tx_src;
    logic        crc_ok, req_ok;
    logic [8:0]  span;
    logic [IDX_W-1:0] reg_idx;
    logic        rf_wr_en;
    logic [15:0] rf_rdata;

    // ---------------- handshakes and packet extents ----------------
    assign rx_ready = (state_q == S_RX);
    assign tx_valid = (state_q == S_TX);
    assign rx_fire  = rx_valid && rx_ready;
    assign tx_fire  = tx_valid && tx_ready;

    assign rx_end  = 8'd3 + ((hdr_q.code == OP_WRITE) ? {1'b0, hdr_q.count, 1'b0} : 8'd0);
    assign rx_last = (rx_idx_q >= 8'd3) && (rx_idx_q == rx_end);
    assign tx_end  = 8'd3 + {1'b0, rcount_q, 1'b0};
    assign tx_last = (tx_idx_q == tx_end);
    assign widx_last = (widx_q == hdr_q.count - 6'd1);

    assign rx_in_buf = ((rx_idx_q - 8'd4) >> 1) < 8'(MAX_REGS);
    assign rx_slot   = BUF_AW'((rx_idx_q - 8'd4) >> 1);
    assign tx_slot   = BUF_AW'((tx_idx_q - 8'd4) >> 1);

    // ---------------- request validation ----------------
    assign span   = {1'b0, off_q} + {3'b000, hdr_q.count};
    assign crc_ok = (rx_sum == crc_in_q);
    assign req_ok = ((hdr_q.code == OP_READ) || (hdr_q.code == OP_WRITE))
                 && (hdr_q.count <= 6'(MAX_REGS))
                 && (page_q < 8'(NUM_PAGES))
                 && (span <= 9'(REGS_PER_PAGE));

    assign reg_idx = IDX_W'(16'(page_q) * 16'(REGS_PER_PAGE) + 16'(off_q) + 16'(widx_q));
    assign rf_wr_en = (state_q == S_WRITE);

    // ---------------- CRC accumulators ----------------
    assign rx_crc_din = (rx_idx_q == 8'd1) ? 8'h00 : rx_byte;

    regpkt_crc8_acc u_rx_crc (
        .clk (clk),
        .rst (rst),
        .clr (tx_fire && tx_last),
        .en  (rx_fire),
        .din (rx_crc_din),
        .crc (rx_sum)
    );

    regpkt_crc8_acc u_tx_crc (
        .clk (clk),
        .rst (rst),
        .clr (state_q == S_CHECK),
        .en  (state_q == S_SUM),
        .din (tx_src),
        .crc (tx_sum)
    );

    // ---------------- register storage ----------------
    regpkt_regfile #(
        .NUM_PAGES     (NUM_PAGES),
        .REGS_PER_PAGE (REGS_PER_PAGE),
        .ALARM_PAGE    (ALARM_PAGE),
        .ALARM_OFFSET  (ALARM_OFFSET)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (rf_wr_en),
        .wr_idx    (reg_idx),
        .wr_data   (buf_q[widx_q[BUF_AW-1:0]]),
        .rd_idx    (reg_idx),
        .rd_data   (rf_rdata),
        .alarm_set (alarm_set)
    );

    // ---------------- reply byte source ----------------
    always_comb begin
        case (tx_idx_q)
            8'd0:    tx_src = {rcode_q, rcount_q};
            8'd1:    tx_src = 8'h00;
            8'd2:    tx_src = page_q;
            8'd3:    tx_src = off_q;
            default: tx_src = tx_idx_q[0] ? buf_q[tx_slot][15:8] : buf_q[tx_slot][7:0];
        endcase
    end

    assign tx_byte = (tx_idx_q == 8'd1) ? tx_sum : tx_src;

    // ---------------- word buffer ----------------
    always_ff @(posedge clk) begin
        if (rx_fire && (rx_idx_q >= 8'd4) && rx_in_buf) begin
            if (rx_idx_q[0]) begin
                buf_q[rx_slot][15:8] <= rx_byte;
            end else begin
                buf_q[rx_slot][7:0] <= rx_byte;
            end
        end
        if (state_q == S_READ) begin
            buf_q[widx_q[BUF_AW-1:0]] <= rf_rdata;
        end
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_RX;
            hdr_q    <= '0;
            crc_in_q <= 8'h00;
            page_q   <= 8'h00;
            off_q    <= 8'h00;
            rx_idx_q <= 8'd0;
            tx_idx_q <= 8'd0;
            widx_q   <= 6'd0;
            rcode_q  <= ST_OK;
            rcount_q <= 6'd0;
        end else begin
            case (state_q)
                S_RX: begin
                    if (rx_fire) begin
                        case (rx_idx_q)
                            8'd0:    hdr_q    <= hdr_t'(rx_byte);
                            8'd1:    crc_in_q <= rx_byte;
                            8'd2:    page_q   <= rx_byte;
                            8'd3:    off_q    <= rx_byte;
                            default: ;
                        endcase
                        if (rx_last) begin
                            rx_idx_q <= 8'd0;
                            state_q  <= S_CHECK;
                        end else begin
                            rx_idx_q <= rx_idx_q + 8'd1;
                        end
                    end
                end
                S_CHECK: begin
                    widx_q   <= 6'd0;
                    tx_idx_q <= 8'd0;
                    rcount_q <= 6'd0;
                    if (!crc_ok) begin
                        rcode_q <= ST_CORRUPT;
                        state_q <= S_SUM;
                    end else if (!req_ok) begin
                        rcode_q <= ST_ERROR;
                        state_q <= S_SUM;
                    end else begin
                        rcode_q <= ST_OK;
                        if (hdr_q.count == 6'd0) begin
                            state_q <= S_SUM;
                        end else if (hdr_q.code == OP_WRITE) begin
                            state_q <= S_WRITE;
                        end else begin
                            rcount_q <= hdr_q.count;
                            state_q  <= S_READ;
                        end
                    end
                end
                S_WRITE, S_READ: begin
                    widx_q <= widx_q + 6'd1;
                    if (widx_last) begin
                        state_q <= S_SUM;
                    end
                end
                S_SUM: begin
                    if (tx_last) begin
                        tx_idx_q <= 8'd0;
                        state_q  <= S_TX;
                    end else begin
                        tx_idx_q <= tx_idx_q + 8'd1;
                    end
                end
                S_TX: begin
                    if (tx_fire) begin
                        if (tx_last) begin
                            tx_idx_q <= 8'd0;
                            state_q  <= S_RX;
                        end else begin
                            tx_idx_q <= tx_idx_q + 8'd1;
                        end
                    end
                end
                default: state_q <= S_RX;
            endcase
        end
    end

endmodule

// File: rtl/regpkt_responder_chk.sv
module regpkt_responder_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic [7:0] tx_idx
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (rx_ready && !tx_valid));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && tx_valid));

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R6
    fail_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_idx == 8'd0 && tx_byte[7:6] != 2'b00) |-> (tx_byte[5:0] == 6'd0));

    // R7
    reply_code_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_idx == 8'd0) |-> (tx_byte[7:6] != 2'b11));

endmodule

bind regpkt_responder regpkt_responder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_byte  (tx_byte),
    .tx_idx   (tx_idx_q)
);

// File: tb/regpkt_responder_bench.sv
module regpkt_responder_bench;

    localparam int NP = 4;
    localparam int RP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [15:0] alarm_set = 16'h0000;

    always #10 clk = ~clk;

    regpkt_responder u_regpkt_responder (
        .clk       (clk),
        .rst       (rst),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .tx_byte   (tx_byte),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .alarm_set (alarm_set)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model [NP*RP];
    logic [7:0]  req [256];
    int          req_len;
    logic [7:0]  exp_b [160];
    int          exp_len;
    logic [15:0] words [64];
    bit          stall_on = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // bit-serial CRC-8, poly 0x07, MSB first
    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            fb = r[7] ^ b[k];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic build_req(input logic [1:0] code, input int cnt, input int pg, input int off,
                             input int nw, input bit bad);
        logic [7:0] c;
        req[0] = {code, 6'(cnt)};
        req[1] = 8'h00;
        req[2] = 8'(pg);
        req[3] = 8'(off);
        for (int i = 0; i < nw; i++) begin
            req[4+2*i] = words[i][7:0];
            req[5+2*i] = words[i][15:8];
        end
        req_len = 4 + 2 * nw;
        c = 8'h00;
        for (int i = 0; i < req_len; i++) c = crc_byte(c, req[i]);
        req[1] = c ^ (bad ? 8'h5A : 8'h00);
    endtask

    task automatic build_exp(input logic [1:0] code, input int cnt, input int pg, input int off);
        logic [7:0] c;
        exp_b[0] = {code, 6'(cnt)};
        exp_b[1] = 8'h00;
        exp_b[2] = 8'(pg);
        exp_b[3] = 8'(off);
        for (int i = 0; i < cnt; i++) begin
            exp_b[4+2*i] = words[i][7:0];
            exp_b[5+2*i] = words[i][15:8];
        end
        exp_len = 4 + 2 * cnt;
        c = 8'h00;
        for (int i = 0; i < exp_len; i++) c = crc_byte(c, exp_b[i]);
        exp_b[1] = c;
    endtask

    task automatic load_words_from_model(input int pg, input int off, input int cnt);
        for (int i = 0; i < cnt; i++) words[i] = model[pg*RP+off+i];
    endtask

    task automatic run_txn(input string tag);
        for (int i = 0; i < req_len; i++) begin
            rx_byte  = req[i];
            rx_valid = 1'b1;
            forever begin
                logic r;
                r = rx_ready;
                @(negedge clk);
                if (r) break;
            end
        end
        rx_valid = 1'b0;
        for (int i = 0; i < exp_len; i++) begin
            while (!tx_valid) @(negedge clk);
            if (stall_on && (i % 2 == 1)) begin
                logic [7:0] held;
                held = tx_byte;
                @(negedge clk);
                check(tx_valid && tx_byte == held && !rx_ready,
                      {tag, " R9 held byte"}, int'(tx_byte), int'(held));
            end
            check(tx_byte == exp_b[i], $sformatf("%s byte %0d", tag, i), int'(tx_byte), int'(exp_b[i]));
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
        end
        check(!tx_valid && rx_ready, {tag, " R2 reply length"}, int'(tx_valid), 0);
    endtask

    task automatic read_back(input int pg, input int off, input int cnt, input string tag);
        build_req(2'b00, cnt, pg, off, 0, 1'b0);
        load_words_from_model(pg, off, cnt);
        build_exp(2'b00, cnt, pg, off);
        run_txn(tag);
    endtask

    task automatic t_reset;
        check(rx_ready == 1'b1, "R1 rx_ready after reset", int'(rx_ready), 1);
        check(tx_valid == 1'b0, "R1 tx_valid after reset", int'(tx_valid), 0);
        read_back(3, 0, 8, "R1 registers zero");
    endtask

    task automatic t_write_basic;
        words[0] = 16'h1234; words[1] = 16'hABCD; words[2] = 16'h00FF;
        build_req(2'b01, 3, 2, 1, 3, 1'b0);
        build_exp(2'b00, 0, 2, 1);
        run_txn("R4 write ack");
        model[2*RP+1] = 16'h1234; model[2*RP+2] = 16'hABCD; model[2*RP+3] = 16'h00FF;
        read_back(2, 1, 3, "R5 read after write");
    endtask

    task automatic t_read_stall;
        stall_on = 1'b1;
        read_back(2, 0, 5, "R9 R3 read under backpressure");
        stall_on = 1'b0;
    endtask

    task automatic t_full_page;
        for (int i = 0; i < RP; i++) words[i] = 16'(i * 16'h1111 + 16'h0107);
        build_req(2'b01, RP, 3, 0, RP, 1'b0);
        build_exp(2'b00, 0, 3, 0);
        run_txn("R4 full page write");
        for (int i = 0; i < RP; i++) model[3*RP+i] = 16'(i * 16'h1111 + 16'h0107);
        read_back(3, 0, RP, "R2 full page read");
        read_back(3, 7, 1, "R5 last slot read");
    endtask

    task automatic t_bad_crc;
        words[0] = 16'hDEAD;
        build_req(2'b01, 1, 2, 1, 1, 1'b1);
        build_exp(2'b01, 0, 2, 1);
        run_txn("R6 corrupt reply");
        read_back(2, 1, 1, "R6 register untouched");
    endtask

    task automatic t_range;
        build_req(2'b00, 1, 4, 0, 0, 1'b0);
        build_exp(2'b10, 0, 4, 0);
        run_txn("R7 page out of range");
        for (int i = 0; i < 3; i++) words[i] = 16'hBEE0 + 16'(i);
        build_req(2'b01, 3, 1, 6, 3, 1'b0);
        build_exp(2'b10, 0, 1, 6);
        run_txn("R7 span past page end");
        for (int i = 0; i < 33; i++) words[i] = 16'hC000 + 16'(i);
        build_req(2'b01, 33, 0, 0, 33, 1'b0);
        build_exp(2'b10, 0, 0, 0);
        run_txn("R7 count above 32");
        build_req(2'b10, 1, 0, 0, 0, 1'b0);
        build_exp(2'b10, 0, 0, 0);
        run_txn("R7 unused request code");
        read_back(0, 0, 8, "R7 page 0 untouched");
        read_back(1, 4, 4, "R7 page 1 tail untouched");
    endtask

    task automatic t_alarm;
        alarm_set = 16'h0005;
        @(negedge clk);
        alarm_set = 16'h0000;
        model[1*RP+3] = 16'h0005;
        read_back(1, 3, 1, "R8 alarm latched");
        words[0] = 16'h7777; words[1] = 16'h0001;
        build_req(2'b01, 2, 1, 2, 2, 1'b0);
        build_exp(2'b00, 0, 1, 2);
        run_txn("R8 write neighbour and clear");
        model[1*RP+2] = 16'h7777;
        model[1*RP+3] = 16'h0004;
        read_back(1, 2, 2, "R8 one bit cleared");
    endtask

    task automatic t_zero;
        build_req(2'b00, 0, 1, 2, 0, 1'b0);
        build_exp(2'b00, 0, 1, 2);
        run_txn("R10 zero-count read");
        build_req(2'b01, 0, 0, 8, 0, 1'b0);
        build_exp(2'b00, 0, 0, 8);
        run_txn("R10 zero-count write at page end");
    endtask

    initial begin
        for (int i = 0; i < NP*RP; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_write_basic;
        t_read_stall;
        t_full_page;
        t_bad_crc;
        t_range;
        t_alarm;
        t_zero;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule